// File: doc/BRIEF.md
# I2C Serial EEPROM Slave Controller

This block is the bus-facing half of a 256-byte serial EEPROM that acts as a slave on a two-wire I2C bus. It brings the raw clock and data lines into the system clock domain and finds Start and Stop conditions. It then receives the control byte and the word address, and drives acknowledge bits and read data onto the open-drain data line through a pull-down enable. It also keeps the internal address pointer that current-address, random and sequential reads rely on.

Written data bytes leave the block one at a time, each with its target address, towards a separate page buffer. A one-cycle commit pulse tells that buffer to start its internal write cycle. The buffer reports the cycle through a busy input. While busy is high the block does not answer its own control byte, so a master can poll for completion. Storage is read through a plain combinational read port driven by the pointer.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: A fall of SDA while SCL is high is a Start and a rise of SDA while SCL is high is a Stop. From any state, a Start restarts reception at bit 7 of a new control byte and a Stop returns the block to idle, even in the middle of a byte.
- R2: After a Start, the first 8 bits received MSB first form the control byte. Bits 7..4 must equal 1010 and bits 3..1 must equal the strap input, and bit 0 selects read (1) or write (0). The block acknowledges by pulling SDA low during the 9th clock only when both fields match. Otherwise it leaves SDA released until the next Start or Stop.
- R3: When the parameter CS_IGNORE is set, bits 3..1 of the control byte are not compared, and any byte whose bits 7..4 are 1010 is acknowledged.
- R4: While writeBusy is high at the end of a control byte, that byte is not acknowledged, whatever its R/W bit. After a non-acknowledged control byte the block stays silent until the next Start or Stop.
- R5: In a write, the byte after the control byte loads the address pointer. Each later byte is acknowledged and produces a one-cycle wrValid with wrAddr set to the pointer and wrData set to the byte. The pointer then advances by one, wrapping from 255 to 0.
- R6: A Stop, or a repeated Start, that follows at least one data byte produces one single-cycle wrCommit pulse. A repeated Start that comes right after the word address produces no wrValid and no wrCommit, and the pointer keeps the loaded address.
- R7: A read sends the byte at the pointer MSB first, so a current-address read returns the byte after the last one accessed. The pointer advances by one after every byte sent.
- R8: In a read, a master acknowledge (SDA low on the 9th clock) makes the block send the byte at the next address. A master non-acknowledge makes it keep SDA released, even if the master keeps clocking, until the next Start or Stop.
- R9: sdaOe changes only a few system clocks after a synchronised SCL fall. It is unchanged two system clocks after SCL falls and holds steady for the whole of every SCL high phase.
- R10: In reset and right after it, sdaOe, wrValid and wrCommit are 0 and the address pointer is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Level of the bus clock line |
| sdaIn | input | 1 | Level of the bus data line |
| sdaOe | output | 1 | 1 pulls the data line low |
| strap | input | CS_W (3) | Chip-select straps compared with control-byte bits 3..1 |
| rdAddr | output | ADDR_W (8) | Storage read address, equal to the pointer |
| rdData | input | DATA_W (8) | Storage read data for rdAddr |
| wrValid | output | 1 | One-cycle strobe for a received data byte |
| wrAddr | output | ADDR_W (8) | Target address of the data byte |
| wrData | output | DATA_W (8) | Data byte for the page buffer |
| wrCommit | output | 1 | One-cycle pulse that starts the write cycle |
| writeBusy | input | 1 | Internal write cycle in progress |

## Verification
The bench acts as a bus master over one shared open-drain line and drives a second copy of the block that ignores the chip-select bits and is kept off the bus. Control bytes with a wrong device code, a wrong chip select and a correct one separate code matching from select matching. Write transactions that end in a Stop, in a repeated Start after the word address, and in a repeated Start after data separate loading the pointer from committing data. Sequential reads ended by an acknowledge and then a non-acknowledge, a write across address 255, a Start in the middle of a byte, and polling during and after the busy window show the pointer arithmetic, the release after a non-acknowledge and the refusal while busy.

// File: rtl/i2c_eeprom_pkg.sv
package i2c_eeprom_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RX,
    S_ACK,
    S_TX,
    S_MACK,
    S_IGNORE
  } slvState_e;

  typedef enum logic [1:0] {
    K_CTRL,
    K_ADDR,
    K_DATA
  } rxKind_e;

  // Strobes from the protocol control to the datapath, one cycle each
  typedef struct packed {
    logic shiftIn;
    logic loadPtr;
    logic incPtr;
    logic emitWr;
    logic driveAck;
    logic loadTx;
    logic shiftTx;
    logic relBus;
    logic commit;
  } ctrlStb_t;

endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startSeen,
  output logic stopSeen
);

  logic [SYNC_STAGES-1:0] sclSync;
  logic [SYNC_STAGES-1:0] sdaSync;
  logic sclPrev;
  logic sdaPrev;
  logic sclLvl;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclSync[g] <= 1'b1;
          sdaSync[g] <= 1'b1;
        end else begin
          sclSync[g] <= sclIn;
          sdaSync[g] <= sdaIn;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclSync[g] <= 1'b1;
          sdaSync[g] <= 1'b1;
        end else begin
          sclSync[g] <= sclSync[g-1];
          sdaSync[g] <= sdaSync[g-1];
        end
      end
    end
  end

  assign sclLvl = sclSync[SYNC_STAGES-1];
  assign sdaLvl = sdaSync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclLvl;
      sdaPrev <= sdaLvl;
    end
  end

  assign sclRise   = sclLvl & ~sclPrev;
  assign sclFall   = ~sclLvl & sclPrev;
  assign startSeen = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopSeen  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;

endmodule

// File: rtl/i2c_slave_ctrl.sv
module i2c_slave_ctrl
  import i2c_eeprom_pkg::*;
#(
  parameter int         DATA_W    = 8,
  parameter int         CS_W      = 3,
  parameter logic [3:0] DEV_CODE  = 4'b1010,
  parameter bit         CS_IGNORE = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startSeen,
  input  logic              stopSeen,
  input  logic              sdaLvl,
  input  logic [DATA_W-1:0] rxByte,
  input  logic [CS_W-1:0]   strap,
  input  logic              writeBusy,
  output ctrlStb_t          stb
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] RX_FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] TX_LAST = CNT_W'(DATA_W - 1);

  slvState_e       state, nState;
  rxKind_e         kind, nKind;
  logic [CNT_W-1:0] bitCnt, nBit;
  logic            isRead, nRead;
  logic            haveData, nHave;
  logic            masterAck, nMack;
  logic            codeHit, csHit;

  assign codeHit = (rxByte[DATA_W-1 -: 4] == DEV_CODE);
  assign csHit   = CS_IGNORE || (rxByte[CS_W:1] == strap);

  always_comb begin
    stb    = '0;
    nState = state;
    nKind  = kind;
    nBit   = bitCnt;
    nRead  = isRead;
    nHave  = haveData;
    nMack  = masterAck;
    if (stopSeen) begin
      stb.relBus = 1'b1;
      stb.commit = haveData;
      nHave      = 1'b0;
      nState     = S_IDLE;
    end else if (startSeen) begin
      stb.relBus = 1'b1;
      stb.commit = haveData;
      nHave      = 1'b0;
      nState     = S_RX;
      nKind      = K_CTRL;
      nBit       = '0;
    end else begin
      case (state)
        S_RX: begin
          if (sclRise) begin
            stb.shiftIn = 1'b1;
            if (bitCnt != RX_FULL) nBit = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == RX_FULL) begin
            case (kind)
              K_CTRL: begin
                if (codeHit && csHit && !writeBusy) begin
                  stb.driveAck = 1'b1;
                  nRead        = rxByte[0];
                  nState       = S_ACK;
                end else begin
                  nState = S_IGNORE;
                end
              end
              K_ADDR: begin
                stb.loadPtr  = 1'b1;
                stb.driveAck = 1'b1;
                nState       = S_ACK;
              end
              default: begin
                stb.emitWr   = 1'b1;
                stb.incPtr   = 1'b1;
                stb.driveAck = 1'b1;
                nHave        = 1'b1;
                nState       = S_ACK;
              end
            endcase
          end
        end
        S_ACK: begin
          if (sclFall) begin
            nBit = '0;
            if (kind == K_CTRL && isRead) begin
              stb.loadTx = 1'b1;
              nState     = S_TX;
            end else begin
              stb.relBus = 1'b1;
              nState     = S_RX;
              nKind      = (kind == K_CTRL) ? K_ADDR : K_DATA;
            end
          end
        end
        S_TX: begin
          if (sclFall) begin
            if (bitCnt == TX_LAST) begin
              stb.relBus = 1'b1;
              stb.incPtr = 1'b1;
              nBit       = '0;
              nState     = S_MACK;
            end else begin
              stb.shiftTx = 1'b1;
              nBit        = bitCnt + 1'b1;
            end
          end
        end
        S_MACK: begin
          if (sclRise) begin
            nMack = ~sdaLvl;
          end else if (sclFall) begin
            if (masterAck) begin
              stb.loadTx = 1'b1;
              nBit       = '0;
              nState     = S_TX;
            end else begin
              nState = S_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      kind      <= K_CTRL;
      bitCnt    <= '0;
      isRead    <= 1'b0;
      haveData  <= 1'b0;
      masterAck <= 1'b0;
    end else begin
      state     <= nState;
      kind      <= nKind;
      bitCnt    <= nBit;
      isRead    <= nRead;
      haveData  <= nHave;
      masterAck <= nMack;
    end
  end

  // R1: a Start always re-arms control-byte reception
  p_start_resets_r1: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |=> (state == S_RX && kind == K_CTRL && bitCnt == '0));

  // R4: no acknowledge of the control byte while the write cycle runs
  p_no_ack_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.driveAck && kind == K_CTRL && state == S_RX) |-> !writeBusy);

  // R8: once ignoring, nothing is put on the bus
  p_ignore_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IGNORE) |-> !(stb.driveAck || stb.loadTx || stb.shiftTx));

  // R9: at most one change of the SDA drive target per cycle
  p_excl_strobes_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.relBus, stb.driveAck, stb.loadTx, stb.shiftTx}));

endmodule

// File: rtl/i2c_slave_datapath.sv
module i2c_slave_datapath
  import i2c_eeprom_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 8,
  parameter int HOLD_CLKS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic              sdaLvl,
  input  logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] rxByte,
  output logic [ADDR_W-1:0] ptr,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              wrCommit,
  output logic              sdaOe
);

  logic [DATA_W-1:0] rxShift;
  logic [DATA_W-1:0] txShift;
  logic              driveTgt;

  assign rxByte = rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift  <= '0;
      txShift  <= '0;
      ptr      <= '0;
      wrValid  <= 1'b0;
      wrAddr   <= '0;
      wrData   <= '0;
      wrCommit <= 1'b0;
      driveTgt <= 1'b0;
    end else begin
      if (stb.shiftIn) rxShift <= {rxShift[DATA_W-2:0], sdaLvl};
      if (stb.loadPtr)      ptr <= rxShift[ADDR_W-1:0];
      else if (stb.incPtr)  ptr <= ptr + 1'b1;
      wrValid  <= stb.emitWr;
      wrCommit <= stb.commit;
      if (stb.emitWr) begin
        wrAddr <= ptr;
        wrData <= rxShift;
      end
      if (stb.loadTx)       txShift <= rdData;
      else if (stb.shiftTx) txShift <= {txShift[DATA_W-2:0], 1'b0};
      if (stb.relBus)        driveTgt <= 1'b0;
      else if (stb.driveAck) driveTgt <= 1'b1;
      else if (stb.loadTx)   driveTgt <= ~rdData[DATA_W-1];
      else if (stb.shiftTx)  driveTgt <= ~txShift[DATA_W-2];
    end
  end

  // Output hold: the drive reaches the pad HOLD_CLKS cycles after its target
  if (HOLD_CLKS == 0) begin : g_hold_none
    assign sdaOe = driveTgt;
  end else if (HOLD_CLKS == 1) begin : g_hold_one
    logic dly;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) dly <= 1'b0;
      else       dly <= driveTgt;
    end
    assign sdaOe = dly;
  end else begin : g_hold_chain
    logic [HOLD_CLKS-1:0] dly;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) dly <= '0;
      else       dly <= {dly[HOLD_CLKS-2:0], driveTgt};
    end
    assign sdaOe = dly[HOLD_CLKS-1];
  end

  // R5: the pointer steps by exactly one per increment strobe
  p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.incPtr && !stb.loadPtr) |=> (ptr == $past(ptr) + 1'b1));

  // R6: commit is a single-cycle pulse
  p_commit_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrCommit |=> !wrCommit);

  // R6: a data byte and a commit never share a cycle
  p_wr_commit_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(wrValid && wrCommit));

endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import i2c_eeprom_pkg::*;
#(
  parameter int         DATA_W      = 8,
  parameter int         ADDR_W      = 8,
  parameter int         CS_W        = 3,
  parameter int         SYNC_STAGES = 2,
  parameter int         HOLD_CLKS   = 3,
  parameter logic [3:0] DEV_CODE    = 4'b1010,
  parameter bit         CS_IGNORE   = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  input  logic [CS_W-1:0]   strap,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] rdData,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              wrCommit,
  input  logic              writeBusy
);

  logic              sdaLvl, sclRise, sclFall, startSeen, stopSeen;
  logic [DATA_W-1:0] rxByte;
  ctrlStb_t          stb;

  i2c_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .sdaLvl    (sdaLvl),
    .sclRise   (sclRise),
    .sclFall   (sclFall),
    .startSeen (startSeen),
    .stopSeen  (stopSeen)
  );

  i2c_slave_ctrl #(
    .DATA_W    (DATA_W),
    .CS_W      (CS_W),
    .DEV_CODE  (DEV_CODE),
    .CS_IGNORE (CS_IGNORE)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sclRise   (sclRise),
    .sclFall   (sclFall),
    .startSeen (startSeen),
    .stopSeen  (stopSeen),
    .sdaLvl    (sdaLvl),
    .rxByte    (rxByte),
    .strap     (strap),
    .writeBusy (writeBusy),
    .stb       (stb)
  );

  i2c_slave_datapath #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .HOLD_CLKS (HOLD_CLKS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .sdaLvl   (sdaLvl),
    .rdData   (rdData),
    .rxByte   (rxByte),
    .ptr      (rdAddr),
    .wrValid  (wrValid),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .wrCommit (wrCommit),
    .sdaOe    (sdaOe)
  );

endmodule

// File: tb/test_i2c_eeprom_slave.sv
`timescale 1ns/1ps
module test_i2c_eeprom_slave;

  localparam int Q          = 8;
  localparam int BUSY_CLKS  = 600;
  localparam int WDOG_LIMIT = 150000;
  localparam logic [7:0] CW = 8'hAA;  // 1010 101 0
  localparam logic [7:0] CR = 8'hAB;  // 1010 101 1

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic sdaOe, sdaOeAny;
  logic busSda;
  logic [7:0] rdAddr, rdData;
  logic wrValid, wrCommit;
  logic [7:0] wrAddr, wrData;
  logic writeBusy;
  logic [7:0] anyRdAddr, anyWrAddr, anyWrData;
  logic anyWrValid, anyWrCommit;

  logic [7:0] mem [256];
  logic [7:0] expMem [256];
  logic [15:0] pend[$];
  logic [15:0] gotWr[$];
  logic [15:0] expWr[$];
  int busyCnt = 0;
  int commitCnt = 0;
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int mPtr = 0;

  always #10 clk = ~clk;

  assign busSda    = mSda & ~sdaOe;
  assign rdData    = mem[rdAddr];
  assign writeBusy = (busyCnt != 0);

  i2c_eeprom_slave i_i2c_eeprom_slave (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(busSda), .sdaOe(sdaOe),
    .strap(3'b101), .rdAddr(rdAddr), .rdData(rdData),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .wrCommit(wrCommit), .writeBusy(writeBusy)
  );

  // Copy that ignores chip select; observed only, kept off the bus
  i2c_eeprom_slave #(.CS_IGNORE(1'b1)) i_i2c_eeprom_slave_any (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(busSda), .sdaOe(sdaOeAny),
    .strap(3'b000), .rdAddr(anyRdAddr), .rdData(8'h00),
    .wrValid(anyWrValid), .wrAddr(anyWrAddr), .wrData(anyWrData),
    .wrCommit(anyWrCommit), .writeBusy(1'b0)
  );

  function automatic logic [7:0] initVal(int a);
    return 8'((a * 13 + 5) & 255);
  endfunction

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Page-buffer and write-cycle model, plus watchdog
  always @(negedge clk) begin
    cycles++;
    if (cycles == WDOG_LIMIT) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, WDOG_LIMIT);
      finishRun();
    end
    if (busyCnt != 0) busyCnt--;
    if (rstN && wrValid) begin
      pend.push_back({wrAddr, wrData});
      gotWr.push_back({wrAddr, wrData});
    end
    if (rstN && wrCommit) begin
      commitCnt++;
      foreach (pend[i]) mem[pend[i][15:8]] = pend[i][7:0];
      pend.delete();
      busyCnt = BUSY_CLKS;
    end
  end

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic busStart();
    mSda = 1'b1; waitClk(Q);
    mScl = 1'b1; waitClk(Q);
    mSda = 1'b0; waitClk(Q);
    mScl = 1'b0; waitClk(Q);
  endtask

  task automatic busStop();
    mSda = 1'b0; waitClk(Q);
    mScl = 1'b1; waitClk(Q);
    mSda = 1'b1; waitClk(Q);
  endtask

  task automatic clockBit(input logic b, output logic seen, output logic seenAny);
    logic oeA, oeB;
    mSda = b; waitClk(Q);
    mScl = 1'b1; waitClk(1); oeA = sdaOe;
    waitClk(Q); seen = busSda; seenAny = sdaOeAny;
    waitClk(Q - 1); oeB = sdaOe;
    chk(oeA == oeB, "R9", "sdaOe steady while SCL high", int'(oeB), int'(oeA));
    mScl = 1'b0; waitClk(2);
    chk(sdaOe == oeB, "R9", "sdaOe held just after SCL fall", int'(sdaOe), int'(oeB));
    waitClk(Q - 2);
  endtask

  task automatic writeByte(input logic [7:0] v, input bit expAck, input int expAny,
                           input string req);
    logic s, sa;
    for (int i = 7; i >= 0; i--) clockBit(v[i], s, sa);
    clockBit(1'b1, s, sa);
    chk((!s) == expAck, req, $sformatf("ack of byte %02h", v), int'(!s), int'(expAck));
    if (expAny >= 0)
      chk(sa == expAny[0], "R3", $sformatf("ack of byte %02h by select-blind copy", v),
          int'(sa), expAny);
  endtask

  task automatic readByte(input logic [7:0] expV, input bit mAck, input string req);
    logic s, sa;
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, s, sa);
      got[i] = s;
    end
    chk(got == expV, req, "read byte", int'(got), int'(expV));
    clockBit(!mAck, s, sa);
  endtask

  task automatic modelWrite(input int addr, input logic [7:0] d);
    expWr.push_back({8'(addr), d});
    expMem[addr & 255] = d;
  endtask

  task automatic expectWrites(input string req);
    chk(gotWr.size() == expWr.size(), req, "number of wrValid strobes",
        gotWr.size(), expWr.size());
    foreach (expWr[i])
      if (i < gotWr.size())
        chk(gotWr[i] == expWr[i], req, "wrAddr/wrData pair", int'(gotWr[i]), int'(expWr[i]));
    gotWr.delete();
    expWr.delete();
  endtask

  task automatic waitIdle();
    while (writeBusy) waitClk(1);
    waitClk(4);
  endtask

  initial begin
    int c0;
    for (int a = 0; a < 256; a++) begin
      mem[a] = initVal(a);
      expMem[a] = initVal(a);
    end
    waitClk(5);
    chk(sdaOe == 1'b0 && wrValid == 1'b0 && wrCommit == 1'b0, "R10", "outputs in reset",
        int'({sdaOe, wrValid, wrCommit}), 0);
    rstN = 1'b1;
    waitClk(3);
    chk(sdaOe == 1'b0 && wrValid == 1'b0 && wrCommit == 1'b0, "R10", "outputs after reset",
        int'({sdaOe, wrValid, wrCommit}), 0);

    // R10/R7: current-address read right after reset returns location 0
    busStart();
    writeByte(CR, 1'b1, 1, "R2");
    readByte(expMem[0], 1'b0, "R10");
    busStop();
    mPtr = 1;

    // R2: wrong device code, nobody answers
    busStart();
    writeByte(8'h9A, 1'b0, 0, "R2");
    busStop();

    // R2/R3: wrong chip select, only the select-blind copy answers
    busStart();
    writeByte(8'hA0, 1'b0, 1, "R2");
    busStop();

    // R5: three-byte write at 0x10, committed by Stop (R6)
    c0 = commitCnt;
    busStart();
    writeByte(CW, 1'b1, -1, "R2");
    writeByte(8'h10, 1'b1, -1, "R5");
    writeByte(8'hA1, 1'b1, -1, "R5"); modelWrite(8'h10, 8'hA1);
    writeByte(8'hB2, 1'b1, -1, "R5"); modelWrite(8'h11, 8'hB2);
    writeByte(8'hC3, 1'b1, -1, "R5"); modelWrite(8'h12, 8'hC3);
    busStop();
    waitClk(4);
    expectWrites("R5");
    chk(commitCnt == c0 + 1, "R6", "commit count after Stop", commitCnt - c0, 1);
    mPtr = 8'h13;

    // R4: polling during the write cycle is refused, then accepted
    busStart();
    writeByte(CW, 1'b0, -1, "R4");
    busStop();
    waitIdle();
    c0 = commitCnt;
    busStart();
    writeByte(CW, 1'b1, -1, "R4");
    busStop();
    waitClk(4);
    chk(commitCnt == c0, "R6", "no commit without data", commitCnt - c0, 0);

    // R6/R8: random read of 0x10 via repeated Start, sequential then NACK
    c0 = commitCnt;
    busStart();
    writeByte(CW, 1'b1, -1, "R2");
    writeByte(8'h10, 1'b1, -1, "R5");
    busStart();
    writeByte(CR, 1'b1, -1, "R2");
    readByte(8'hA1, 1'b1, "R8");
    readByte(8'hB2, 1'b1, "R8");
    readByte(8'hC3, 1'b0, "R8");
    readByte(8'hFF, 1'b0, "R8");  // SDA stays released after NACK
    busStop();
    waitClk(4);
    expectWrites("R6");
    chk(commitCnt == c0, "R6", "no commit after address-only write", commitCnt - c0, 0);
    mPtr = 8'h13;

    // R7: current-address read continues after the last byte sent
    busStart();
    writeByte(CR, 1'b1, -1, "R7");
    readByte(expMem[mPtr], 1'b0, "R7");
    busStop();
    mPtr = mPtr + 1;

    // R5: write across address 255 wraps the pointer to 0
    busStart();
    writeByte(CW, 1'b1, -1, "R5");
    writeByte(8'hFF, 1'b1, -1, "R5");
    writeByte(8'h77, 1'b1, -1, "R5"); modelWrite(8'hFF, 8'h77);
    writeByte(8'h88, 1'b1, -1, "R5"); modelWrite(8'h00, 8'h88);
    busStop();
    waitClk(4);
    expectWrites("R5");
    waitIdle();
    mPtr = 1;
    busStart();
    writeByte(CR, 1'b1, -1, "R7");
    readByte(expMem[mPtr], 1'b0, "R5");
    busStop();
    mPtr = 2;

    // R1: Start in the middle of the word address restarts the control byte
    busStart();
    writeByte(CW, 1'b1, -1, "R1");
    begin
      logic s, sa;
      for (int i = 7; i >= 4; i--) clockBit(8'h3C >> i, s, sa);
    end
    busStart();
    writeByte(CR, 1'b1, -1, "R1");
    readByte(expMem[mPtr], 1'b0, "R1");
    busStop();
    mPtr = 3;

    // R6/R4: repeated Start after data commits; the read then sees busy
    c0 = commitCnt;
    busStart();
    writeByte(CW, 1'b1, -1, "R6");
    writeByte(8'h40, 1'b1, -1, "R6");
    writeByte(8'h11, 1'b1, -1, "R6"); modelWrite(8'h40, 8'h11);
    busStart();
    writeByte(CR, 1'b0, -1, "R4");
    busStop();
    waitClk(4);
    expectWrites("R6");
    chk(commitCnt == c0 + 1, "R6", "commit on repeated Start after data", commitCnt - c0, 1);
    waitIdle();
    mPtr = 8'h41;
    busStart();
    writeByte(CR, 1'b1, -1, "R7");
    readByte(expMem[mPtr], 1'b0, "R7");
    busStop();

    waitClk(10);
    finishRun();
  end

endmodule